// File: doc/BRIEF.md
# Parallel Eight-Point FFT Datapath

This block computes an eight-point discrete Fourier transform of complex, signed, fixed-point samples in one combinational pass. All eight input samples are presented together on two packed buses, one for real parts and one for imaginary parts. All eight frequency bins appear on two output buses in natural bin order. There is no clock, no register and no handshake. The result is valid as soon as the logic settles after any input change, so the block can sit inside any pipeline stage of the surrounding design.

Internally the samples are wired in bit-reversed order into three ranks of four radix-2 butterflies, twelve in all. Each butterfly outputs the sum of its two legs on the upper leg and the difference on the lower leg. Before each butterfly, a fixed twiddle rotation is applied to the lower leg. Rotations by 1 and by -j are pure rewiring and negation. The two diagonal rotations use a 16-bit constant with 14 fractional bits and four real products. Each product is truncated toward negative infinity. Every rank widens the data by two bits, so no input in the signed range can overflow.

Top module: `fft8_par`

## Requirements
- R1: Sample n occupies slice n of `x_re`/`x_im` and bin k occupies slice k of `y_re`/`y_im`, all in two's complement. Bin 0 equals the exact sum of the eight inputs, real and imaginary separately.
- R2: Bin 4 equals the exact alternating sum x0 - x1 + x2 - ... - x7.
- R3: Bin 2 equals the exact sum of x(n)·(-j)^n, and bin 6 equals the exact sum of x(n)·(+j)^n.
- R4: Each component of bins 1, 3, 5 and 7 lies within 1.25 of the real-valued DFT of the inputs.
- R5: For k = 1 and 3, bin k plus bin k+4 equals exactly twice the four-point DFT of the even-indexed samples at index k.
- R6: The diagonal rotation constant is 11585 at 2^-14, and products are floored. An input of 127 in the real part of sample 1, with all else zero, gives bin 1 = 89-90j, bin 3 = -90-90j, bin 5 = -89+90j and bin 7 = 90+90j.
- R7: The output width is the input width plus 6. R1 to R5 hold for inputs at the extremes of the signed range.
- R8: Outputs depend on the current inputs only. They are correct within the same clock cycle as an input change, and all-zero inputs give all-zero outputs.
- R9: The input x(n) = n + nj gives bin 0 = 28+28j, bin 2 = -8+0j, bin 4 = -4-4j and bin 6 = 0-8j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_re | input | 8×IN_W | Real parts of samples 0..7, slice n is sample n |
| x_im | input | 8×IN_W | Imaginary parts of samples 0..7 |
| y_re | output | 8×(IN_W+6) | Real parts of bins 0..7, slice k is bin k |
| y_im | output | 8×(IN_W+6) | Imaginary parts of bins 0..7 |

## Verification
Every bin is due in the same cycle as the input change that caused it, with zero registers on the path. The bench therefore drives a new vector on the falling clock edge and samples every bin 1 ns later, well before the next rising edge. It never waits for an extra cycle, so any added stage of delay shows up as a mismatch. The sweep covers single impulses at each position at both signed extremes, all-extreme and alternating-extreme vectors, the ramp and a long pseudo-random series. The even bins are compared exactly and the odd bins against a real-valued DFT within the stated bound.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
    localparam int NPT     = 8;
    localparam int NSTG    = 3;
    localparam int GROW    = 2;
    localparam int TW_W    = 16;
    localparam int TW_FRAC = 14;
    localparam int C45_I   = int'(real'(1 << TW_FRAC) * 0.7071067811865476);
    localparam logic signed [TW_W-1:0] C45 = TW_W'(C45_I);

    // rotation by W8^k for k = 0..3
    typedef enum logic [1:0] {TW_ONE, TW_P45, TW_NJ, TW_P135} tw_kind_e;

    function automatic int bitrev(input int i);
        int r;
        r = 0;
        for (int b = 0; b < NSTG; b++)
            if (((i >> b) & 1) != 0) r = r | (1 << (NSTG - 1 - b));
        return r;
    endfunction

    function automatic tw_kind_e tw_of(input int k);
        return tw_kind_e'(k[1:0]);
    endfunction
endpackage

// File: rtl/fft8_twiddle.sv
module fft8_twiddle
    import fft8_pkg::*;
#(
    parameter int       W    = 8,
    parameter tw_kind_e KIND = TW_ONE
) (
    input  logic signed [W-1:0] b_re,
    input  logic signed [W-1:0] b_im,
    output logic signed [W:0]   r_re,
    output logic signed [W:0]   r_im
);
    localparam int PW = W + 1 + TW_W;

    logic signed [W:0] re_x;
    logic signed [W:0] im_x;
    assign re_x = {b_re[W-1], b_re};
    assign im_x = {b_im[W-1], b_im};

    generate
        if (KIND == TW_ONE) begin : g_one
            assign r_re = re_x;
            assign r_im = im_x;
        end else if (KIND == TW_NJ) begin : g_nj
            assign r_re = im_x;
            assign r_im = -re_x;
        end else begin : g_diag
            logic signed [W:0]    s_sum;
            logic signed [W:0]    s_dif;
            logic signed [PW-1:0] p_re;
            logic signed [PW-1:0] p_im;
            logic                 unused_bits;
            assign s_sum = re_x + im_x;
            assign s_dif = im_x - re_x;
            if (KIND == TW_P45) begin : g_p45
                assign p_re = PW'(s_sum) * PW'(C45);
                assign p_im = PW'(s_dif) * PW'(C45);
            end else begin : g_p135
                assign p_re = PW'(s_dif) * PW'(C45);
                assign p_im = -(PW'(s_sum) * PW'(C45));
            end
            // dropping the low fraction bits floors the product
            assign r_re = p_re[TW_FRAC +: W+1];
            assign r_im = p_im[TW_FRAC +: W+1];
            assign unused_bits = ^{p_re[PW-1:TW_FRAC+W+1], p_re[TW_FRAC-1:0],
                                   p_im[PW-1:TW_FRAC+W+1], p_im[TW_FRAC-1:0]};
        end
    endgenerate
endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly #(
    parameter int W = 9
) (
    input  logic signed [W-1:0] a_re,
    input  logic signed [W-1:0] a_im,
    input  logic signed [W-1:0] b_re,
    input  logic signed [W-1:0] b_im,
    output logic signed [W:0]   s_re,
    output logic signed [W:0]   s_im,
    output logic signed [W:0]   d_re,
    output logic signed [W:0]   d_im
);
    logic signed [W:0] ar, ai, br, bi;
    assign ar = {a_re[W-1], a_re};
    assign ai = {a_im[W-1], a_im};
    assign br = {b_re[W-1], b_re};
    assign bi = {b_im[W-1], b_im};

    assign s_re = ar + br;
    assign s_im = ai + bi;
    assign d_re = ar - br;
    assign d_im = ai - bi;
endmodule

// File: rtl/fft8_stage.sv
module fft8_stage
    import fft8_pkg::*;
#(
    parameter int W = 8,
    parameter int S = 0
) (
    input  logic [NPT-1:0][W-1:0]      d_re,
    input  logic [NPT-1:0][W-1:0]      d_im,
    output logic [NPT-1:0][W+GROW-1:0] q_re,
    output logic [NPT-1:0][W+GROW-1:0] q_im
);
    localparam int SPAN = 1 << S;

    generate
        for (genvar b = 0; b < NPT/2; b++) begin : g_bf
            localparam int OFF = b % SPAN;
            localparam int TOP = (b / SPAN) * 2 * SPAN + OFF;
            localparam int BOT = TOP + SPAN;
            localparam int K   = OFF * (NPT / (2 * SPAN));

            logic signed [W:0] up_re, up_im, lo_re, lo_im;
            assign up_re = {d_re[TOP][W-1], d_re[TOP]};
            assign up_im = {d_im[TOP][W-1], d_im[TOP]};

            fft8_twiddle #(.W(W), .KIND(tw_of(K))) tw_i (
                .b_re (d_re[BOT]),
                .b_im (d_im[BOT]),
                .r_re (lo_re),
                .r_im (lo_im)
            );

            fft8_bfly #(.W(W+1)) bf_i (
                .a_re (up_re),
                .a_im (up_im),
                .b_re (lo_re),
                .b_im (lo_im),
                .s_re (q_re[TOP]),
                .s_im (q_im[TOP]),
                .d_re (q_re[BOT]),
                .d_im (q_im[BOT])
            );
        end
    endgenerate
endmodule

// File: rtl/fft8_par.sv
module fft8_par
    import fft8_pkg::*;
#(
    parameter  int IN_W  = 8,
    localparam int OUT_W = IN_W + NSTG * GROW
) (
    input  logic [NPT-1:0][IN_W-1:0]  x_re,
    input  logic [NPT-1:0][IN_W-1:0]  x_im,
    output logic [NPT-1:0][OUT_W-1:0] y_re,
    output logic [NPT-1:0][OUT_W-1:0] y_im
);
    localparam int W1 = IN_W + GROW;
    localparam int W2 = W1 + GROW;

    logic [NPT-1:0][IN_W-1:0] s0_re, s0_im;
    logic [NPT-1:0][W1-1:0]   s1_re, s1_im;
    logic [NPT-1:0][W2-1:0]   s2_re, s2_im;

    generate
        for (genvar i = 0; i < NPT; i++) begin : g_perm
            assign s0_re[i] = x_re[bitrev(i)];
            assign s0_im[i] = x_im[bitrev(i)];
        end
    endgenerate

    fft8_stage #(.W(IN_W), .S(0)) st0_i (.d_re(s0_re), .d_im(s0_im), .q_re(s1_re), .q_im(s1_im));
    fft8_stage #(.W(W1),   .S(1)) st1_i (.d_re(s1_re), .d_im(s1_im), .q_re(s2_re), .q_im(s2_im));
    fft8_stage #(.W(W2),   .S(2)) st2_i (.d_re(s2_re), .d_im(s2_im), .q_re(y_re),  .q_im(y_im));
endmodule

// File: rtl/fft8_par_chk.sv
module fft8_par_chk
    import fft8_pkg::*;
#(
    parameter  int IN_W  = 8,
    localparam int OUT_W = IN_W + NSTG * GROW
) (
    input logic [NPT-1:0][IN_W-1:0]  x_re,
    input logic [NPT-1:0][IN_W-1:0]  x_im,
    input logic [NPT-1:0][OUT_W-1:0] y_re,
    input logic [NPT-1:0][OUT_W-1:0] y_im
);
    always_comb begin
        int sr, si, ar, ai, e2r, e2i, e6r, e6i, o1r, o1i, o3r, o3i;
        int vr, vi;
        sr = 0; si = 0; ar = 0; ai = 0;
        e2r = 0; e2i = 0; e6r = 0; e6i = 0;
        o1r = 0; o1i = 0; o3r = 0; o3i = 0;
        for (int n = 0; n < NPT; n++) begin
            vr = int'($signed(x_re[n]));
            vi = int'($signed(x_im[n]));
            sr += vr; si += vi;
            if (n % 2 == 0) begin ar += vr; ai += vi; end
            else            begin ar -= vr; ai -= vi; end
            unique case (n % 4)
                0: begin e2r += vr; e2i += vi; e6r += vr; e6i += vi; end
                1: begin e2r += vi; e2i -= vr; e6r -= vi; e6i += vr; end
                2: begin e2r -= vr; e2i -= vi; e6r -= vr; e6i -= vi; end
                default: begin e2r -= vi; e2i += vr; e6r += vi; e6i -= vr; end
            endcase
            if (n % 2 == 0) begin
                unique case ((n / 2) % 4)
                    0: begin o1r += vr; o1i += vi; o3r += vr; o3i += vi; end
                    1: begin o1r += vi; o1i -= vr; o3r -= vi; o3i += vr; end
                    2: begin o1r -= vr; o1i -= vi; o3r -= vr; o3i -= vi; end
                    default: begin o1r -= vi; o1i += vr; o3r += vi; o3i -= vr; end
                endcase
            end
        end
        // R1
        bin0_sum_chk: assert (int'($signed(y_re[0])) == sr && int'($signed(y_im[0])) == si);
        // R2
        bin4_alt_chk: assert (int'($signed(y_re[4])) == ar && int'($signed(y_im[4])) == ai);
        // R3
        bin2_rot_chk: assert (int'($signed(y_re[2])) == e2r && int'($signed(y_im[2])) == e2i);
        // R3
        bin6_rot_chk: assert (int'($signed(y_re[6])) == e6r && int'($signed(y_im[6])) == e6i);
        // R5
        pair15_chk: assert (int'($signed(y_re[1])) + int'($signed(y_re[5])) == 2 * o1r &&
                            int'($signed(y_im[1])) + int'($signed(y_im[5])) == 2 * o1i);
        // R5
        pair37_chk: assert (int'($signed(y_re[3])) + int'($signed(y_re[7])) == 2 * o3r &&
                            int'($signed(y_im[3])) + int'($signed(y_im[7])) == 2 * o3i);
    end
endmodule

bind fft8_par fft8_par_chk #(.IN_W(IN_W)) chk_i (
    .x_re (x_re),
    .x_im (x_im),
    .y_re (y_re),
    .y_im (y_im)
);

// File: tb/fft8_par_tb_top.sv
module fft8_par_tb_top;
    localparam int  IN_W  = 8;
    localparam int  OUT_W = IN_W + 6;
    localparam int  NPT   = 8;
    localparam int  VMAX  = (1 << (IN_W - 1)) - 1;
    localparam int  VMIN  = -(1 << (IN_W - 1));
    localparam real PI    = 3.14159265358979;
    localparam real TOL   = 1.25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NPT-1:0][IN_W-1:0]  x_re, x_im;
    logic [NPT-1:0][OUT_W-1:0] y_re, y_im;

    fft8_par #(.IN_W(IN_W)) dut_i (.x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int xr[NPT];
    int xi[NPT];

    function automatic int gr(input int k); return int'($signed(y_re[k])); endfunction
    function automatic int gi(input int k); return int'($signed(y_im[k])); endfunction

    task automatic chk_eq(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic chk_near(input string what, input int got, input real exp);
        real d;
        n_chk++;
        d = real'(got) - exp;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %f", what, got, exp);
        end
    endtask

    task automatic apply();
        @(negedge clk);
        for (int i = 0; i < NPT; i++) begin
            x_re[i] = IN_W'(xr[i]);
            x_im[i] = IN_W'(xi[i]);
        end
        #1; // R8: sampled 1 ns after the change, before the next rising edge
    endtask

    task automatic check_all(input string tag);
        int sr, si, ar, ai, e2r, e2i, e6r, e6i, o1r, o1i, o3r, o3i;
        sr = 0; si = 0; ar = 0; ai = 0; e2r = 0; e2i = 0; e6r = 0; e6i = 0;
        o1r = 0; o1i = 0; o3r = 0; o3i = 0;
        for (int n = 0; n < NPT; n++) begin
            sr += xr[n]; si += xi[n];
            ar += (n % 2 == 0) ? xr[n] : -xr[n];
            ai += (n % 2 == 0) ? xi[n] : -xi[n];
            case (n % 4)
                0: begin e2r += xr[n]; e2i += xi[n]; e6r += xr[n]; e6i += xi[n]; end
                1: begin e2r += xi[n]; e2i -= xr[n]; e6r -= xi[n]; e6i += xr[n]; end
                2: begin e2r -= xr[n]; e2i -= xi[n]; e6r -= xr[n]; e6i -= xi[n]; end
                default: begin e2r -= xi[n]; e2i += xr[n]; e6r += xi[n]; e6i -= xr[n]; end
            endcase
        end
        for (int m = 0; m < 4; m++) begin
            case (m)
                0: begin o1r += xr[0]; o1i += xi[0]; o3r += xr[0]; o3i += xi[0]; end
                1: begin o1r += xi[2]; o1i -= xr[2]; o3r -= xi[2]; o3i += xr[2]; end
                2: begin o1r -= xr[4]; o1i -= xi[4]; o3r -= xr[4]; o3i -= xi[4]; end
                default: begin o1r -= xi[6]; o1i += xr[6]; o3r += xi[6]; o3i -= xr[6]; end
            endcase
        end
        chk_eq({tag, " R1 bin0 re"}, gr(0), sr);
        chk_eq({tag, " R1 bin0 im"}, gi(0), si);
        chk_eq({tag, " R2 bin4 re"}, gr(4), ar);
        chk_eq({tag, " R2 bin4 im"}, gi(4), ai);
        chk_eq({tag, " R3 bin2 re"}, gr(2), e2r);
        chk_eq({tag, " R3 bin2 im"}, gi(2), e2i);
        chk_eq({tag, " R3 bin6 re"}, gr(6), e6r);
        chk_eq({tag, " R3 bin6 im"}, gi(6), e6i);
        chk_eq({tag, " R5 pair1 re"}, gr(1) + gr(5), 2 * o1r);
        chk_eq({tag, " R5 pair1 im"}, gi(1) + gi(5), 2 * o1i);
        chk_eq({tag, " R5 pair3 re"}, gr(3) + gr(7), 2 * o3r);
        chk_eq({tag, " R5 pair3 im"}, gi(3) + gi(7), 2 * o3i);
        for (int k = 1; k < NPT; k += 2) begin
            real rr, ri, ang;
            rr = 0.0; ri = 0.0;
            for (int n = 0; n < NPT; n++) begin
                ang = -2.0 * PI * real'(k * n) / real'(NPT);
                rr += real'(xr[n]) * $cos(ang) - real'(xi[n]) * $sin(ang);
                ri += real'(xr[n]) * $sin(ang) + real'(xi[n]) * $cos(ang);
            end
            chk_near($sformatf("%s R4 bin%0d re", tag, k), gr(k), rr);
            chk_near($sformatf("%s R4 bin%0d im", tag, k), gi(k), ri);
        end
    endtask

    task automatic clear();
        for (int i = 0; i < NPT; i++) begin xr[i] = 0; xi[i] = 0; end
    endtask

    initial begin
        #500us;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        clear();
        x_re = '0;
        x_im = '0;
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < NPT; k++) begin // R8 reset state, zero in gives zero out
            chk_eq($sformatf("R8 zero bin%0d re", k), gr(k), 0);
            chk_eq($sformatf("R8 zero bin%0d im", k), gi(k), 0);
        end
        rst_n = 1'b1;

        // R9 ramp
        for (int n = 0; n < NPT; n++) begin xr[n] = n; xi[n] = n; end
        apply();
        chk_eq("R9 bin0 re", gr(0), 28);  chk_eq("R9 bin0 im", gi(0), 28);
        chk_eq("R9 bin2 re", gr(2), -8);  chk_eq("R9 bin2 im", gi(2), 0);
        chk_eq("R9 bin4 re", gr(4), -4);  chk_eq("R9 bin4 im", gi(4), -4);
        chk_eq("R9 bin6 re", gr(6), 0);   chk_eq("R9 bin6 im", gi(6), -8);
        check_all("ramp");

        // R6 quantized rotation with flooring
        clear();
        xr[1] = 127;
        apply();
        chk_eq("R6 bin1 re", gr(1), 89);  chk_eq("R6 bin1 im", gi(1), -90);
        chk_eq("R6 bin3 re", gr(3), -90); chk_eq("R6 bin3 im", gi(3), -90);
        chk_eq("R6 bin5 re", gr(5), -89); chk_eq("R6 bin5 im", gi(5), 90);
        chk_eq("R6 bin7 re", gr(7), 90);  chk_eq("R6 bin7 im", gi(7), 90);

        // impulses at every position, both extremes, real and imaginary
        for (int p = 0; p < NPT; p++) begin
            for (int v = 0; v < 4; v++) begin
                clear();
                if (v < 2) xr[p] = (v == 0) ? VMAX : VMIN;
                else       xi[p] = (v == 2) ? VMAX : VMIN;
                apply();
                check_all($sformatf("R7 impulse p%0d v%0d", p, v));
            end
        end

        // R7 full-scale vectors
        for (int i = 0; i < NPT; i++) begin xr[i] = VMAX; xi[i] = VMAX; end
        apply(); check_all("R7 all max");
        for (int i = 0; i < NPT; i++) begin xr[i] = VMIN; xi[i] = VMIN; end
        apply(); check_all("R7 all min");
        for (int i = 0; i < NPT; i++) begin
            xr[i] = (i % 2 == 0) ? VMAX : VMIN;
            xi[i] = (i % 2 == 0) ? VMIN : VMAX;
        end
        apply(); check_all("R7 alternating");
        for (int i = 0; i < NPT; i++) begin
            xr[i] = ((i / 2) % 2 == 0) ? VMIN : VMAX;
            xi[i] = (i % 2 == 0) ? VMIN : VMAX;
        end
        apply(); check_all("R7 paired");

        // pseudo-random sweep
        seed = 32'h1ace_b00c;
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < NPT; i++) begin
                seed = seed ^ (seed << 13);
                seed = seed ^ (seed >>> 17) & 32'h0000_7fff;
                seed = seed ^ (seed << 5);
                xr[i] = ((seed >> 4) & 255) - 128;
                xi[i] = ((seed >> 12) & 255) - 128;
            end
            apply();
            check_all($sformatf("R4 random %0d", t));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule